// File: doc/BRIEF.md
# Read-Data Checker with Error Capture

This block sits behind a memory traffic source and checks the data that comes back from memory against the data that should have come back, one beat at a time. A beat is compared only when the expected-data valid and the read-data valid are both high in the same cycle. Any mismatch produces a one-cycle compare-error pulse and sets a sticky error flag.

On the first mismatch after reset or clear, the block freezes a fixed-layout diagnostic record. The record holds the start address and burst length of the read command in progress, three controller queue flags sampled in that cycle, and both data words of the failing beat. The record and the sticky flag hold until a synchronous clear. Producing the expected data is left to the surrounding logic.

Top module: `rd_check_capture`

## Requirements
- R1: After a synchronous reset, cmp_error, error and every bit of error_status are 0.
- R2: When both valids are high in a cycle and exp_data differs from rd_data in any bit, cmp_error is 1 in the following cycle; when they are equal, cmp_error is 0 in the following cycle.
- R3: A cycle in which exp_valid or rd_valid is low performs no comparison: cmp_error is 0 in the next cycle and error and error_status do not change, whatever the data inputs hold.
- R4: error goes to 1 in the cycle after the first mismatching beat and stays 1 until clear is asserted.
- R5: On the first mismatch the record is loaded from that cycle's inputs: [31:0] cmd_addr, [37:32] cmd_len, bit 40 cmd_full, bit 41 wr_full, bit 42 rd_empty, [64+DATA_W-1:64] exp_data, [64+2*DATA_W-1:64+DATA_W] rd_data.
- R6: Mismatches while error is already 1 still pulse cmp_error but leave error_status unchanged.
- R7: Bits [39:38] and [63:43] of error_status are always 0.
- R8: clear is synchronous: in the cycle after it is high, cmp_error, error and error_status are all 0, even if a mismatching beat arrived in the same cycle as clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clear | input | 1 | Synchronous clear of the flags and record |
| exp_data | input | DATA_W | Expected data for the current beat |
| exp_valid | input | 1 | exp_data is valid |
| rd_data | input | DATA_W | Data read back from memory |
| rd_valid | input | 1 | rd_data is valid |
| cmd_addr | input | 32 | Start address of the read command in progress |
| cmd_len | input | 6 | Burst length of that command |
| cmd_full | input | 1 | Controller command queue full |
| wr_full | input | 1 | Controller write-data queue full |
| rd_empty | input | 1 | Controller read-data queue empty |
| cmp_error | output | 1 | Registered per-beat mismatch pulse |
| error | output | 1 | Sticky mismatch flag |
| error_status | output | 64+2*DATA_W | Diagnostic record of the first mismatch |

## Verification
The bench builds the block with DATA_W set to 16 and LANE_W kept at 8, so the record is 96 bits and the compare splits into two byte lanes. That width lets the checks flip a single bit at either end of the word and in either lane, and confirm that the expected and read words land at bits 64 and 80 without overlap. Every queue flag is driven both ways across mismatches so each record bit is seen set and clear.

// File: rtl/rdc_pkg.sv
package rdc_pkg;
  localparam int unsigned REC_ADDR_W = 32;
  localparam int unsigned REC_LEN_W  = 6;
  localparam int unsigned REC_LEN_LO = REC_ADDR_W;
  localparam int unsigned REC_FLG_LO = 40;
  localparam int unsigned REC_HDR_W  = 64;
  localparam int unsigned REC_PAD_W  = REC_HDR_W - REC_FLG_LO - 3;

  typedef struct packed {
    logic rd_empty;
    logic wr_full;
    logic cmd_full;
  } q_flags_t;
endpackage

// File: rtl/rdc_compare.sv
module rdc_compare #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LANE_W = 8
) (
  input  logic [DATA_W-1:0] exp_data,
  input  logic              exp_valid,
  input  logic [DATA_W-1:0] rd_data,
  input  logic              rd_valid,
  output logic              miss
);
  localparam int unsigned LANES = (DATA_W + LANE_W - 1) / LANE_W;

  logic [LANES-1:0] lane_diff;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam int unsigned LO = i * LANE_W;
    localparam int unsigned HI = (LO + LANE_W > DATA_W) ? DATA_W - 1 : LO + LANE_W - 1;
    assign lane_diff[i] = |(exp_data[HI:LO] ^ rd_data[HI:LO]);
  end

  assign miss = exp_valid & rd_valid & (|lane_diff);
endmodule

// File: rtl/rdc_record.sv
module rdc_record
  import rdc_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [REC_ADDR_W-1:0]   cmd_addr,
  input  logic [REC_LEN_W-1:0]    cmd_len,
  input  q_flags_t                flags,
  input  logic [DATA_W-1:0]       exp_data,
  input  logic [DATA_W-1:0]       rd_data,
  output logic [REC_HDR_W+2*DATA_W-1:0] rec
);
  localparam int unsigned GAP_W = REC_FLG_LO - REC_LEN_LO - REC_LEN_W;

  always_comb begin
    rec = {rd_data, exp_data, {REC_PAD_W{1'b0}},
           flags.rd_empty, flags.wr_full, flags.cmd_full,
           {GAP_W{1'b0}}, cmd_len, cmd_addr};
  end
endmodule

// File: rtl/rdc_capture.sv
module rdc_capture #(
  parameter int unsigned REC_W = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             miss,
  input  logic [REC_W-1:0] rec,
  output logic             cmp_error,
  output logic             error,
  output logic [REC_W-1:0] error_status
);
  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cmp_error    <= 1'b0;
      error        <= 1'b0;
      error_status <= '0;
    end else begin
      cmp_error <= miss;
      if (miss && !error) begin
        error        <= 1'b1;
        error_status <= rec;
      end
    end
  end
endmodule

// File: rtl/rd_check_capture.sv
module rd_check_capture
  import rdc_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LANE_W = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        clear,
  input  logic [DATA_W-1:0]           exp_data,
  input  logic                        exp_valid,
  input  logic [DATA_W-1:0]           rd_data,
  input  logic                        rd_valid,
  input  logic [31:0]                 cmd_addr,
  input  logic [5:0]                  cmd_len,
  input  logic                        cmd_full,
  input  logic                        wr_full,
  input  logic                        rd_empty,
  output logic                        cmp_error,
  output logic                        error,
  output logic [63+2*DATA_W:0]        error_status
);
  localparam int unsigned REC_W = REC_HDR_W + 2 * DATA_W;

  logic             miss;
  logic [REC_W-1:0] rec;
  q_flags_t         flags;

  assign flags = '{rd_empty: rd_empty, wr_full: wr_full, cmd_full: cmd_full};

  rdc_compare #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_cmp (
    .exp_data (exp_data),
    .exp_valid(exp_valid),
    .rd_data  (rd_data),
    .rd_valid (rd_valid),
    .miss     (miss)
  );

  rdc_record #(.DATA_W(DATA_W)) u_rec (
    .cmd_addr(cmd_addr),
    .cmd_len (cmd_len),
    .flags   (flags),
    .exp_data(exp_data),
    .rd_data (rd_data),
    .rec     (rec)
  );

  rdc_capture #(.REC_W(REC_W)) u_cap (
    .clk         (clk),
    .rst         (rst),
    .clear       (clear),
    .miss        (miss),
    .rec         (rec),
    .cmp_error   (cmp_error),
    .error       (error),
    .error_status(error_status)
  );
endmodule

// File: rtl/rdc_checker.sv
module rdc_checker #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LANE_W = 8
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 clear,
  input logic [DATA_W-1:0]    exp_data,
  input logic                 exp_valid,
  input logic [DATA_W-1:0]    rd_data,
  input logic                 rd_valid,
  input logic [31:0]          cmd_addr,
  input logic [5:0]           cmd_len,
  input logic                 cmd_full,
  input logic                 wr_full,
  input logic                 rd_empty,
  input logic                 cmp_error,
  input logic                 error,
  input logic [63+2*DATA_W:0] error_status
);
  // R2
  mismatch_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (exp_valid && rd_valid && exp_data != rd_data && !clear) |=> cmp_error);

  // R3
  no_compare_chk: assert property (@(posedge clk) disable iff (rst)
    !(exp_valid && rd_valid) |=> !cmp_error);

  // R4
  sticky_error_chk: assert property (@(posedge clk) disable iff (rst)
    (error && !clear) |=> error);

  // R6
  record_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (error && !clear) |=> $stable(error_status));

  // R8
  clear_all_chk: assert property (@(posedge clk) disable iff (rst)
    clear |=> (!error && !cmp_error && error_status == '0));

  // R7
  reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (error_status[63:43] == '0) && (error_status[39:38] == '0));

  // R1
  always @(posedge clk) begin
    if ($past(rst, 1) === 1'b1) begin
      reset_state_chk: assert (!cmp_error && !error && error_status == '0);
    end
  end
endmodule

bind rd_check_capture rdc_checker #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_rdc_chk (.*);

// File: tb/rd_check_capture_test.sv
module rd_check_capture_test;
  localparam int DW = 16;
  localparam int SW = 64 + 2 * DW;
  localparam time CLK_PERIOD = 10ns;

  logic          clk = 1'b0;
  logic          rst, clear;
  logic [DW-1:0] exp_data, rd_data;
  logic          exp_valid, rd_valid;
  logic [31:0]   cmd_addr;
  logic [5:0]    cmd_len;
  logic          cmd_full, wr_full, rd_empty;
  logic          cmp_error, error;
  logic [SW-1:0] error_status;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  rd_check_capture #(.DATA_W(DW), .LANE_W(8)) uut (
    .clk(clk), .rst(rst), .clear(clear),
    .exp_data(exp_data), .exp_valid(exp_valid),
    .rd_data(rd_data), .rd_valid(rd_valid),
    .cmd_addr(cmd_addr), .cmd_len(cmd_len),
    .cmd_full(cmd_full), .wr_full(wr_full), .rd_empty(rd_empty),
    .cmp_error(cmp_error), .error(error), .error_status(error_status)
  );

  function automatic logic [SW-1:0] mk_rec(logic [31:0] a, logic [5:0] l,
      logic cf, logic wf, logic re, logic [DW-1:0] e, logic [DW-1:0] r);
    return {r, e, 21'b0, re, wf, cf, 2'b0, l, a};
  endfunction

  task automatic chk(string req, logic [SW-1:0] act, logic [SW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    clear = 0; exp_valid = 0; rd_valid = 0;
  endtask

  // drive one cycle of inputs, then sample after the edge that registers them
  task automatic beat(logic ev, logic [DW-1:0] e, logic rv, logic [DW-1:0] r,
                      logic [31:0] a, logic [5:0] l, logic cf, logic wf, logic re,
                      logic clr);
    @(negedge clk);
    exp_valid = ev; exp_data = e; rd_valid = rv; rd_data = r;
    cmd_addr = a; cmd_len = l; cmd_full = cf; wr_full = wf; rd_empty = re;
    clear = clr;
    @(negedge clk);
    idle();
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst = 1; idle();
    exp_data = 16'h1234; rd_data = 16'h4321; cmd_addr = 0; cmd_len = 0;
    cmd_full = 0; wr_full = 0; rd_empty = 0;
    @(negedge clk); @(negedge clk);
    rst = 0;
    chk("R1 cmp_error", SW'(cmp_error), '0);
    chk("R1 error", SW'(error), '0);
    chk("R1 status", error_status, '0);
  endtask

  task automatic t_match();
    beat(1, 16'hA5A5, 1, 16'hA5A5, 32'h10, 6'd4, 1, 1, 1, 0);
    chk("R2 equal no pulse", SW'(cmp_error), '0);
    chk("R2 equal no error", SW'(error), '0);
  endtask

  task automatic t_one_valid();
    beat(1, 16'h0001, 0, 16'hFFFE, 32'h20, 6'd2, 0, 0, 0, 0);
    chk("R3 rd_valid low", SW'(cmp_error), '0);
    beat(0, 16'h0001, 1, 16'hFFFE, 32'h20, 6'd2, 0, 0, 0, 0);
    chk("R3 exp_valid low", SW'(cmp_error), '0);
    chk("R3 error untouched", SW'(error), '0);
    chk("R3 status untouched", error_status, '0);
  endtask

  task automatic t_first_miss();
    beat(1, 16'h8000, 1, 16'h0000, 32'hDEAD_BEEF, 6'd37, 1, 0, 1, 0);
    chk("R2 msb flip pulse", SW'(cmp_error), 1);
    chk("R4 error set", SW'(error), 1);
    chk("R5 record", error_status,
        mk_rec(32'hDEAD_BEEF, 6'd37, 1, 0, 1, 16'h8000, 16'h0000));
    chk("R7 reserved", SW'({error_status[63:43], error_status[39:38]}), '0);
    @(negedge clk);
    chk("R2 pulse ends", SW'(cmp_error), '0);
    chk("R4 error held", SW'(error), 1);
  endtask

  task automatic t_second_miss();
    beat(1, 16'h0001, 1, 16'h0000, 32'h0000_0040, 6'd1, 0, 1, 0, 0);
    chk("R6 second pulse", SW'(cmp_error), 1);
    chk("R6 record kept", error_status,
        mk_rec(32'hDEAD_BEEF, 6'd37, 1, 0, 1, 16'h8000, 16'h0000));
  endtask

  task automatic t_clear();
    beat(0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    chk("R8 clear error", SW'(error), '0);
    chk("R8 clear status", error_status, '0);
    // new first mismatch loads again, low lane bit 0 and upper lane
    beat(1, 16'h00FF, 1, 16'h01FE, 32'h1234_5678, 6'd63, 0, 1, 0, 0);
    chk("R5 reload", error_status,
        mk_rec(32'h1234_5678, 6'd63, 0, 1, 0, 16'h00FF, 16'h01FE));
    chk("R4 error again", SW'(error), 1);
  endtask

  task automatic t_clear_priority();
    beat(1, 16'hFFFF, 1, 16'h0000, 32'h5, 6'd5, 1, 1, 1, 1);
    chk("R8 clear wins pulse", SW'(cmp_error), '0);
    chk("R8 clear wins error", SW'(error), '0);
    chk("R8 clear wins status", error_status, '0);
    beat(1, 16'h0100, 1, 16'h0000, 32'hFFFF_FFFF, 6'd0, 0, 0, 1, 0);
    chk("R5 upper lane", error_status,
        mk_rec(32'hFFFF_FFFF, 6'd0, 0, 0, 1, 16'h0100, 16'h0000));
  endtask

  initial begin
    t_reset();
    t_match();
    t_one_valid();
    t_first_miss();
    t_second_miss();
    t_clear();
    t_clear_priority();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule